// File: doc/BRIEF.md
# Transmit Statistics Half-Range Interrupt Unit

The unit keeps three transmit statistics counters: good frames, good frames sent after exactly one collision, and good frames sent after two or more collisions. Each counter has its own one-cycle increment pulse. When a counter's most significant bit turns from 0 to 1, which means it has reached half of its range, a sticky flag for that counter is set in a 32-bit status word. A flag stays set until software reads the counter that raised it with a read that includes the lowest byte lane of that counter.

A 32-bit mask word with the same bit layout chooses which flags drive the single interrupt output. Reads go through a plain register port. The port takes a byte address, a read strobe and four byte-lane enables. The data appears one cycle after the strobe and is qualified by a valid pin. The port is a control and status path, so it has no back-pressure: a strobe is accepted in every cycle. The mask is loaded through its own write strobe and data pins.

Top module: `txstat_hf_irq`

## Requirements
- R1: After reset, all counters, the status word and the mask read as zero, and the interrupt output is low.
- R2: Each increment pulse adds one to its counter. A counter wraps from all-ones to zero. The counters are read, zero-extended to 32 bits, at byte offset 0x110 (good), 0x114 (single collision) and 0x118 (multiple collisions). Read data and the valid pin appear in the cycle after the read strobe. The data is the counter value from before that cycle's increment.
- R3: The status word is at offset 0x108. Bit 21 is set when the good counter's MSB goes from 0 to 1. Bit 14 is set in the same way by the single-collision counter, and bit 15 by the multiple-collision counter. A wrap from all-ones to zero does not set a bit.
- R4: A status bit stays set until its own counter is read with byte-lane enable bit 0 high. A counter read with enable bit 0 low leaves the bit set.
- R5: Reading the status word clears no bit. All status bits other than 21, 15 and 14 read as zero.
- R6: If a clearing read of a counter and that counter's MSB 0-to-1 transition fall in the same cycle, the status bit ends up set.
- R7: The mask is at offset 0x10C. A write strobe loads it. Only bits 21, 15 and 14 are stored, and the other bits read as zero. The interrupt output is the OR of the status bits whose mask bits are set.
- R8: A read of any other word offset returns zero. Byte lanes whose enable bit is low return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | 3 | Increment pulses: [0] good, [1] single collision, [2] multiple collisions |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Byte address of the read; bits [1:0] are ignored |
| rd_be_i | input | 4 | Byte-lane enables of the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | 32 | Read data |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 32 | Mask write data |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume that a read that clears a flag names the counter by its exact word offset. They also assume that reset is held for at least one clock edge before the first check. The bench builds the unit with 6-bit counters so that half range is reached after 32 pulses. It drives every strobe and pulse at the falling edge and keeps each pulse one cycle long. Only the set-wins scenario puts a read and an increment in the same cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int NUM_CNT = 3;
  localparam int WORD_W  = 32;
  localparam logic [11:0] OFF_STATUS = 12'h108;
  localparam logic [11:0] OFF_MASK   = 12'h10C;
  localparam logic [11:0] OFF_CNT0   = 12'h110;
  localparam logic [WORD_W-1:0] STAT_MAP = (32'h1 << 21) | (32'h1 << 15) | (32'h1 << 14);

  // status bit owned by counter index: 0 good, 1 single collision, 2 multiple
  function automatic int stat_bit(input int idx);
    case (idx)
      0:       return 21;
      1:       return 14;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             msb_rise_o
);
  localparam logic [CNT_W-1:0] BELOW_HALF = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o      = cnt_q;
  assign msb_rise_o = inc_i && (cnt_q == BELOW_HALF);
endmodule

// File: rtl/hf_flags.sv
module hf_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rd_decode.sv
module rd_decode #(
  parameter int ADDR_W = 12,
  parameter int N      = 3
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     rd_en_i,
  input  logic [3:0]               be_i,
  input  logic [N-1:0][31:0]       cnt_i,
  input  logic [31:0]              status_i,
  input  logic [31:0]              mask_i,
  output logic [31:0]              data_o,
  output logic [N-1:0]             clr_o
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] WA_STATUS = WA_W'(txstat_pkg::OFF_STATUS >> 2);
  localparam logic [WA_W-1:0] WA_MASK   = WA_W'(txstat_pkg::OFF_MASK >> 2);
  localparam logic [WA_W-1:0] WA_CNT0   = WA_W'(txstat_pkg::OFF_CNT0 >> 2);

  logic [WA_W-1:0] wa;
  logic [N-1:0]    hit_cnt;
  logic [31:0]     word;
  logic [31:0]     lane_mask;

  assign wa = addr_i[ADDR_W-1:2];

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit_cnt[i] = (wa == WA_CNT0 + WA_W'(i));
    assign clr_o[i]   = rd_en_i && be_i[0] && hit_cnt[i];
  end

  always_comb begin
    word = '0;
    if (wa == WA_STATUS) word = status_i;
    if (wa == WA_MASK)   word = mask_i;
    for (int i = 0; i < N; i++)
      if (hit_cnt[i]) word = cnt_i[i];
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{be_i[b]}};
  end

  assign data_o = word & lane_mask;
endmodule

// File: rtl/txstat_hf_irq.sv
module txstat_hf_irq #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        inc_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [3:0]        rd_be_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  input  logic              mask_we_i,
  input  logic [31:0]       mask_wdata_i,
  output logic              irq_o
);
  import txstat_pkg::*;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0][31:0]      cnt_ext;
  logic [NUM_CNT-1:0]            msb_rise;
  logic [NUM_CNT-1:0]            clr;
  logic [NUM_CNT-1:0]            flag;
  logic [31:0]                   status_word;
  logic [31:0]                   mask_q;
  logic [31:0]                   rd_word;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (inc_i[i]),
      .cnt_o      (cnt[i]),
      .msb_rise_o (msb_rise[i])
    );
    assign cnt_ext[i] = 32'(cnt[i]);
  end

  hf_flags #(.N(NUM_CNT)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (msb_rise),
    .clr_i  (clr),
    .flag_o (flag)
  );

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NUM_CNT; i++) status_word[stat_bit(i)] = flag[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i & STAT_MAP;
  end

  rd_decode #(.ADDR_W(ADDR_W), .N(NUM_CNT)) u_dec (
    .addr_i   (rd_addr_i),
    .rd_en_i  (rd_en_i),
    .be_i     (rd_be_i),
    .cnt_i    (cnt_ext),
    .status_i (status_word),
    .mask_i   (mask_q),
    .data_o   (rd_word),
    .clr_o    (clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_en_i ? rd_word : '0;
    end
  end

  assign irq_o = |(status_word & mask_q);
endmodule

// File: rtl/txstat_hf_irq_chk.sv
module txstat_hf_irq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [3:0]        rd_be_i,
  input logic              rd_valid_o,
  input logic              irq_o,
  input logic [31:0]       status_word
);
  localparam logic [ADDR_W-1:0] A_GOOD = ADDR_W'(12'h110);
  localparam logic [ADDR_W-1:0] A_MULT = ADDR_W'(12'h118);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (status_word == 32'h0 && !irq_o));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~txstat_pkg::STAT_MAP) == 32'h0);

  // R4
  sticky_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[21] && !(rd_en_i && rd_be_i[0] && rd_addr_i[ADDR_W-1:2] == A_GOOD[ADDR_W-1:2]))
    |=> status_word[21]);

  // R4
  sticky_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15] && !(rd_en_i && rd_be_i[0] && rd_addr_i[ADDR_W-1:2] == A_MULT[ADDR_W-1:2]))
    |=> status_word[15]);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_word != 32'h0);

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind txstat_hf_irq txstat_hf_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_be_i     (rd_be_i),
  .rd_valid_o  (rd_valid_o),
  .irq_o       (irq_o),
  .status_word (status_word)
);

// File: tb/sim_txstat_hf_irq.sv
module sim_txstat_hf_irq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam logic [11:0] A_STAT = 12'h108, A_MASK = 12'h10C;
  localparam logic [11:0] A_GOOD = 12'h110, A_SCOL = 12'h114, A_MCOL = 12'h118;
  localparam logic [31:0] B_GOOD = 32'h1 << 21, B_SCOL = 32'h1 << 14, B_MCOL = 32'h1 << 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] inc = '0;
  logic rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [3:0] rd_be = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txstat_hf_irq #(.CNT_W(CW), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_be_i(rd_be), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      inc[idx] = 1'b1;
      @(negedge clk);
      inc[idx] = 1'b0;
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a; rd_be = be;
    @(negedge clk);
    rd_en = 1'b0;
    check("R2 valid", {31'h0, rd_valid}, 32'h1);
    d = rd_data;
  endtask

  task automatic wr_mask(input logic [31:0] v);
    mask_we = 1'b1; mask_wdata = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(A_STAT, 4'hF, d); check("R1 status", d, 32'h0);
    rd(A_GOOD, 4'hF, d); check("R1 good", d, 32'h0);
    rd(A_MASK, 4'hF, d); check("R1 mask", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    pulse(0, 5); pulse(1, 3); pulse(2, 7);
    rd(A_GOOD, 4'hF, d); check("R2 good", d, 32'd5);
    rd(A_SCOL, 4'hF, d); check("R2 single", d, 32'd3);
    rd(A_MCOL, 4'hF, d); check("R2 multi", d, 32'd7);
    rd(A_MCOL, 4'b0010, d); check("R8 lane off", d, 32'h0);
    rd(A_STAT, 4'hF, d); check("R3 none yet", d, 32'h0);
  endtask

  task automatic t_half();
    logic [31:0] d;
    pulse(0, 27);
    rd(A_STAT, 4'hF, d); check("R3 good set", d, B_GOOD);
    rd(A_STAT, 4'hF, d); check("R5 status read keeps", d, B_GOOD);
    rd(A_GOOD, 4'b1110, d); check("R8 lane0 masked", d, 32'h0);
    rd(A_STAT, 4'hF, d); check("R4 upper lanes keep", d, B_GOOD);
    rd(A_GOOD, 4'b0001, d); check("R2 good at half", d, 32'd32);
    rd(A_STAT, 4'hF, d); check("R4 cleared", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pulse(1, 29);
    rd(A_STAT, 4'hF, d); check("R3 single bit14", d, B_SCOL);
    check("R7 masked irq low", {31'h0, irq}, 32'h0);
    wr_mask(B_SCOL);
    check("R7 irq high", {31'h0, irq}, 32'h1);
    rd(A_MASK, 4'hF, d); check("R7 mask read", d, B_SCOL);
    wr_mask(32'hFFFF_FFFF);
    rd(A_MASK, 4'hF, d); check("R7 mask reserved", d, B_GOOD | B_SCOL | B_MCOL);
    rd(A_SCOL, 4'hF, d); check("R2 single", d, 32'd32);
    check("R7 irq after clear", {31'h0, irq}, 32'h0);
    wr_mask(32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    pulse(0, 32);
    rd(A_GOOD, 4'hF, d); check("R2 wrap zero", d, 32'h0);
    rd(A_STAT, 4'hF, d); check("R3 wrap no set", d, 32'h0);
    pulse(0, 32);
    rd(A_STAT, 4'hF, d); check("R3 set again", d, B_GOOD);
    rd(A_GOOD, 4'h1, d); check("R2 good", d, 32'd32);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    pulse(2, 24);
    inc[2] = 1'b1; rd_en = 1'b1; rd_addr = A_MCOL; rd_be = 4'hF;
    @(negedge clk);
    inc[2] = 1'b0; rd_en = 1'b0;
    check("R6 read value", rd_data, 32'd31);
    rd(A_STAT, 4'hF, d); check("R6 set wins", d, B_MCOL);
    rd(A_MCOL, 4'hF, d); check("R4 multi clear read", d, 32'd32);
    rd(A_STAT, 4'hF, d); check("R4 multi cleared", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h200, 4'hF, d); check("R8 unmapped 0x200", d, 32'h0);
    rd(12'h11C, 4'hF, d); check("R8 unmapped 0x11C", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_half();
    t_mask();
    t_wrap();
    t_setwins();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule